// File: doc/BRIEF.md
# Serial Memory Page-Write Controller

This block is the write side of a two-wire serial slave that fronts a small nonvolatile memory. It watches the clock and data lines of the bus, which have already been filtered, and pulls the data line low to acknowledge. A transaction opens with a start condition. The master then sends a device select byte, a one-byte memory address and any number of data bytes. The data bytes are collected in a 16-byte page latch. The location within the page advances after each byte and wraps from the last location back to the first. The page number given by the upper address bits never changes during a transaction.

A stop condition that follows a complete data byte begins a fixed-length busy period. During it, the block copies every latch location that was loaded in this transaction to an external storage array, one byte per clock through a simple write port. Locations that were not loaded are never written. While busy, the block ignores the bus completely. A start or stop that interrupts a byte, or a stop that comes before any data byte, throws away whatever was staged.

Top module: `pageWriteCtl`

## Requirements
- R1: The select byte is accepted only when it equals {DEV_ID_BASE[6:SEL_W], selStrap, 0}, which is 8'hAA with the defaults and strap 3'b101. Bit 0 is the direction bit, and 0 means write. On a mismatch the block does not acknowledge and ignores everything until the next start condition.
- R2: Every accepted byte is acknowledged. sdaDriveLow is high from the scl fall that ends bit 8 to the scl fall that ends bit 9, and it changes only while scl is low.
- R3: The address byte splits into a page number in bits [7:4] and a start location in bits [3:0]. Data byte k of a transaction goes to location (start + k) mod 16 of that page.
- R4: After more than 16 data bytes, each later byte replaces the byte already staged at its location. Starting at location 10 with 13 bytes, the 13th byte lands at location 6.
- R5: A stop that comes after at least one data byte, and no later than the first scl pulse of the next byte, raises busy for exactly BUSY_CYCLES clock cycles.
- R6: During busy, each staged location is written exactly once through memWe/memAddr/memWdata, in ascending location order. Unstaged locations keep their old contents, and memWe is never high outside busy.
- R7: While busy is high, all bus activity is ignored: no acknowledge is given, and nothing staged then gets written.
- R8: A stop before any data byte starts no busy period and writes nothing.
- R9: A stop after two or more scl pulses of a byte is an abort, and so is any start condition. An abort discards all staged bytes, and a start also begins a new select byte.
- R10: During reset, sdaDriveLow, busy and memWe are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| scl | input | 1 | Filtered bus clock |
| sdaIn | input | 1 | Filtered bus data as seen on the wire |
| selStrap | input | SEL_W | Device select strap |
| sdaDriveLow | output | 1 | Pull the data line low (acknowledge) |
| busy | output | 1 | Commit period in progress |
| memWe | output | 1 | Storage write enable |
| memAddr | output | 8 | Storage write address |
| memWdata | output | 8 | Storage write data |

## Verification
The main sweep writes to every start location of the page. At each location it sends 1, 12, 13 and 17 bytes, and it changes the page number on every pass. A single byte shows that neighbouring locations stay untouched. Twelve bytes from a high location show the wrap to location 0. Thirteen bytes show where the pointer stops. Seventeen bytes show one byte overwriting an earlier one. After each commit the bench compares the whole page with an arithmetic model, together with the number of storage writes and the length of busy. Separate patterns cover a wrong strap, the read direction bit, a stop after only the address, a stop in the middle of a byte, a repeated start, and a new transaction sent during busy. Each of these tells apart the paths that discard staged data or ignore the bus from the path that commits.

// File: rtl/pageWritePkg.sv
`timescale 1ns/1ps
package pageWritePkg;

  // Strobes from the bus sequencer to the page datapath
  typedef struct packed {
    logic shiftBit;
    logic loadAddr;
    logic stageByte;
    logic clearMask;
    logic commitReset;
    logic commitStep;
  } pwStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK,
    ST_SKIP,
    ST_BUSY
  } pwState_t;

  typedef enum logic [1:0] {
    K_DEV,
    K_ADDR,
    K_DATA
  } pwKind_t;

endpackage

// File: rtl/pageWriteDp.sv
`timescale 1ns/1ps
module pageWriteDp
  import pageWritePkg::*;
#(
  parameter int PAGE_BYTES = 16,
  parameter int SEL_W = 3,
  parameter logic [6:0] DEV_ID_BASE = 7'b1010_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwStrobe_t         strobe,
  input  logic              sdaBit,
  input  logic [SEL_W-1:0]  selStrap,
  output logic              devMatch,
  output logic              anyValid,
  output logic              memWe,
  output logic [7:0]        memAddr,
  output logic [7:0]        memWdata
);

  localparam int ADDR_W = 8;
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int IDX_W  = OFF_W + 1;

  logic [7:0]        shiftReg;
  logic [PAGE_W-1:0] pageBase;
  logic [OFF_W-1:0]  wrOff;
  logic [IDX_W-1:0]  commitIdx;
  logic [7:0]        pageLatch [PAGE_BYTES];
  logic              validMask [PAGE_BYTES];

  // Compare the received select byte, direction bit must be write (0)
  assign devMatch = (shiftReg == {DEV_ID_BASE[6:SEL_W], selStrap, 1'b0});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      pageBase <= '0;
      wrOff    <= '0;
    end else begin
      if (strobe.shiftBit) shiftReg <= {shiftReg[6:0], sdaBit};
      if (strobe.loadAddr) begin
        pageBase <= shiftReg[ADDR_W-1:OFF_W];
        wrOff    <= shiftReg[OFF_W-1:0];
      end else if (strobe.stageByte) begin
        wrOff <= wrOff + 1'b1;   // wraps inside the page
      end
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : gLoc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pageLatch[g] <= '0;
        validMask[g] <= 1'b0;
      end else if (strobe.stageByte && wrOff == OFF_W'(g)) begin
        pageLatch[g] <= shiftReg;
        validMask[g] <= 1'b1;
      end else if (strobe.clearMask) begin
        validMask[g] <= 1'b0;
      end
    end
  end

  always_comb begin
    anyValid = 1'b0;
    for (int i = 0; i < PAGE_BYTES; i++) anyValid = anyValid | validMask[i];
  end

  // Commit walker: one location per busy cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      commitIdx <= '0;
    end else if (strobe.commitReset) begin
      commitIdx <= '0;
    end else if (strobe.commitStep && commitIdx < IDX_W'(PAGE_BYTES)) begin
      commitIdx <= commitIdx + 1'b1;
    end
  end

  assign memWe    = strobe.commitStep && (commitIdx < IDX_W'(PAGE_BYTES))
                    && validMask[commitIdx[OFF_W-1:0]];
  assign memAddr  = {pageBase, commitIdx[OFF_W-1:0]};
  assign memWdata = pageLatch[commitIdx[OFF_W-1:0]];

endmodule

// File: rtl/pageWriteFsm.sv
`timescale 1ns/1ps
module pageWriteFsm
  import pageWritePkg::*;
#(
  parameter int BUSY_CYCLES = 64
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      scl,
  input  logic      sdaIn,
  input  logic      devMatch,
  input  logic      anyValid,
  output pwStrobe_t strobe,
  output logic      busy,
  output logic      sdaDriveLow
);

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  pwState_t         state, stateN;
  pwKind_t          kind, kindN;
  logic [3:0]       bitCnt, bitCntN;
  logic [CNT_W-1:0] busyCnt, busyCntN;
  logic             sclQ, sdaQ;
  logic             sclRise, sclFall, startSeen, stopSeen;

  assign sclRise   = scl & ~sclQ;
  assign sclFall   = ~scl & sclQ;
  assign startSeen = scl & sclQ & sdaQ & ~sdaIn;
  assign stopSeen  = scl & sclQ & ~sdaQ & sdaIn;

  always_comb begin
    stateN   = state;
    kindN    = kind;
    bitCntN  = bitCnt;
    busyCntN = busyCnt;
    strobe   = '0;
    if (state == ST_BUSY) begin
      strobe.commitStep = 1'b1;
      busyCntN = busyCnt + 1'b1;
      if (busyCnt == CNT_W'(BUSY_CYCLES - 1)) begin
        stateN           = ST_IDLE;
        busyCntN         = '0;
        strobe.clearMask = 1'b1;
      end
    end else if (startSeen) begin
      stateN           = ST_RECV;
      kindN            = K_DEV;
      bitCntN          = '0;
      strobe.clearMask = 1'b1;
    end else if (stopSeen) begin
      if (state == ST_RECV && kind == K_DATA && bitCnt <= 4'd1 && anyValid) begin
        stateN             = ST_BUSY;
        busyCntN           = '0;
        strobe.commitReset = 1'b1;
      end else begin
        stateN           = ST_IDLE;
        strobe.clearMask = 1'b1;
      end
    end else begin
      case (state)
        ST_RECV: begin
          if (sclRise && bitCnt < 4'd8) begin
            strobe.shiftBit = 1'b1;
            bitCntN = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == 4'd8) begin
            case (kind)
              K_DEV:   stateN = devMatch ? ST_ACK : ST_SKIP;
              K_ADDR:  begin strobe.loadAddr = 1'b1;  stateN = ST_ACK; end
              default: begin strobe.stageByte = 1'b1; stateN = ST_ACK; end
            endcase
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            stateN  = ST_RECV;
            bitCntN = '0;
            kindN   = (kind == K_DEV) ? K_ADDR : K_DATA;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      kind    <= K_DEV;
      bitCnt  <= '0;
      busyCnt <= '0;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      state   <= stateN;
      kind    <= kindN;
      bitCnt  <= bitCntN;
      busyCnt <= busyCntN;
      sclQ    <= scl;
      sdaQ    <= sdaIn;
    end
  end

  assign busy        = (state == ST_BUSY);
  assign sdaDriveLow = (state == ST_ACK);

endmodule

// File: rtl/pageWriteCtl.sv
`timescale 1ns/1ps
module pageWriteCtl
  import pageWritePkg::*;
#(
  parameter int PAGE_BYTES = 16,
  parameter int BUSY_CYCLES = 64,
  parameter int SEL_W = 3,
  parameter logic [6:0] DEV_ID_BASE = 7'b1010_000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             scl,
  input  logic             sdaIn,
  input  logic [SEL_W-1:0] selStrap,
  output logic             sdaDriveLow,
  output logic             busy,
  output logic             memWe,
  output logic [7:0]       memAddr,
  output logic [7:0]       memWdata
);

  pwStrobe_t strobe;
  logic      devMatch;
  logic      anyValid;

  pageWriteFsm #(.BUSY_CYCLES(BUSY_CYCLES)) uFsm (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaIn),
    .devMatch(devMatch), .anyValid(anyValid),
    .strobe(strobe), .busy(busy), .sdaDriveLow(sdaDriveLow)
  );

  pageWriteDp #(
    .PAGE_BYTES(PAGE_BYTES), .SEL_W(SEL_W), .DEV_ID_BASE(DEV_ID_BASE)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaBit(sdaIn),
    .selStrap(selStrap), .devMatch(devMatch), .anyValid(anyValid),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata)
  );

endmodule

// File: rtl/pageWriteCtlChk.sv
`timescale 1ns/1ps
module pageWriteCtlChk #(
  parameter int PAGE_BYTES = 16,
  parameter int BUSY_CYCLES = 64
) (
  input logic       clk,
  input logic       rstN,
  input logic       scl,
  input logic       sdaDriveLow,
  input logic       busy,
  input logic       memWe,
  input logic [7:0] memAddr
);

  localparam int OFF_W = $clog2(PAGE_BYTES);

  int busyLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyLen <= 0;
    else if (busy) busyLen <= busyLen + 1;
    else busyLen <= 0;
  end

  // R2: acknowledge drive only moves while scl is low
  p_ack_edge_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !scl);

  // R3: one commit stays inside a single page
  p_same_page_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $past(memWe)) |-> memAddr[7:OFF_W] == $past(memAddr[7:OFF_W]));

  // R5: busy lasts exactly the configured number of cycles
  p_busy_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyLen == BUSY_CYCLES);

  p_busy_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> busyLen < BUSY_CYCLES);

  // R6: storage writes only while busy, ascending locations
  p_we_in_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);

  p_ascending_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $past(memWe)) |->
      memAddr[OFF_W-1:0] == OFF_W'($past(memAddr[OFF_W-1:0]) + 1'b1));

  // R7: no acknowledge while busy
  p_quiet_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaDriveLow);

endmodule

bind pageWriteCtl pageWriteCtlChk #(
  .PAGE_BYTES(PAGE_BYTES), .BUSY_CYCLES(BUSY_CYCLES)
) uChk (
  .clk(clk), .rstN(rstN), .scl(scl), .sdaDriveLow(sdaDriveLow),
  .busy(busy), .memWe(memWe), .memAddr(memAddr)
);

// File: tb/pageWriteCtl_test.sv
`timescale 1ns/1ps
module pageWriteCtl_test;

  localparam int BUSY = 120;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic sdaIn;
  logic [2:0] selStrap = 3'b101;
  logic sdaDriveLow, busy, memWe;
  logic [7:0] memAddr, memWdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] benchMem [256];
  logic [7:0] expMem [256];
  int wrCnt = 0;
  int busyRises = 0;
  int busyRun = 0;
  int lastLen = 0;
  logic busyQ = 1'b0;

  always #4 clk = ~clk;

  assign sdaIn = sdaM & ~sdaDriveLow;

  pageWriteCtl #(.BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaIn), .selStrap(selStrap),
    .sdaDriveLow(sdaDriveLow), .busy(busy), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) benchMem[i] <= 8'h00;
    end else begin
      if (memWe) begin
        benchMem[memAddr] <= memWdata;
        wrCnt <= wrCnt + 1;
      end
      busyQ <= busy;
      if (busy && !busyQ) busyRises <= busyRises + 1;
      if (busy) busyRun <= busyRun + 1;
      else if (busyRun != 0) begin
        lastLen <= busyRun;
        busyRun <= 0;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; tick(2); scl = 1'b1; tick(2);
    sdaM = 1'b0; tick(4); scl = 1'b0; tick(2);
  endtask

  task automatic busStop();
    sdaM = 1'b0; tick(2); scl = 1'b1; tick(2);
    sdaM = 1'b1; tick(4);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sdaM = b[7-i]; tick(2); scl = 1'b1; tick(4); scl = 1'b0; tick(2);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    sendBits(b, 8);
    sdaM = 1'b1; tick(2); scl = 1'b1; tick(2);
    acked = sdaDriveLow;
    tick(2); scl = 1'b0; tick(2);
  endtask

  task automatic waitIdle();
    int guard = 0;
    tick(1);
    while (busy && guard < 5000) begin tick(1); guard++; end
    tick(2);
  endtask

  function automatic logic [7:0] dataVal(input int t, input int i);
    return 8'((t * 29 + i * 13 + 7) & 255);
  endfunction

  task automatic cmpPage(input string req, input int page);
    for (int l = 0; l < 16; l++)
      chk(req, {24'h0, benchMem[page*16+l]}, {24'h0, expMem[page*16+l]});
  endtask

  // Full page write: R1, R2, R3, R4, R5, R6
  task automatic pageWrite(input int t, input int page, input int off, input int count);
    logic a;
    int wb;
    busStart();
    sendByte(8'hAA, a);                    chk("R1 select ack", {31'h0, a}, 1);
    sendByte(8'(page*16 + off), a);        chk("R2 address ack", {31'h0, a}, 1);
    for (int i = 0; i < count; i++) begin
      sendByte(dataVal(t, i), a);          chk("R2 data ack", {31'h0, a}, 1);
      expMem[page*16 + ((off + i) % 16)] = dataVal(t, i);
    end
    wb = wrCnt;
    busStop();
    waitIdle();
    chk("R5 busy length", lastLen, BUSY);
    chk("R6 write count", wrCnt - wb, (count > 16) ? 16 : count);
    // R4: overwrite and pointer position are checked by the page contents
    cmpPage((count > 12) ? "R4 page contents" : "R3 page contents", page);
  endtask

  initial begin
    logic a;
    int wb, rb;
    for (int i = 0; i < 256; i++) expMem[i] = 8'h00;
    tick(3);
    chk("R10 sdaDriveLow in reset", {31'h0, sdaDriveLow}, 0);
    chk("R10 busy in reset", {31'h0, busy}, 0);
    chk("R10 memWe in reset", {31'h0, memWe}, 0);
    tick(2);
    rstN = 1'b1;
    tick(4);

    // R1: wrong strap value, then traffic that must be ignored
    wb = wrCnt; rb = busyRises;
    busStart();
    sendByte(8'hA6, a);  chk("R1 wrong strap nack", {31'h0, a}, 0);
    sendByte(8'h20, a);  chk("R1 ignored addr nack", {31'h0, a}, 0);
    sendByte(8'h55, a);  chk("R1 ignored data nack", {31'h0, a}, 0);
    busStop(); tick(10);
    chk("R1 no write after mismatch", wrCnt - wb, 0);
    chk("R1 no busy after mismatch", busyRises - rb, 0);

    // R1: read direction bit set
    busStart();
    sendByte(8'hAB, a);  chk("R1 read bit nack", {31'h0, a}, 0);
    busStop(); tick(10);

    // R8: stop right after the address byte
    wb = wrCnt; rb = busyRises;
    busStart();
    sendByte(8'hAA, a);  chk("R1 select ack", {31'h0, a}, 1);
    sendByte(8'h35, a);  chk("R2 address ack", {31'h0, a}, 1);
    busStop(); tick(10);
    chk("R8 no busy without data", busyRises - rb, 0);
    chk("R8 no write without data", wrCnt - wb, 0);

    // R9: stop in the middle of a data byte
    wb = wrCnt; rb = busyRises;
    busStart();
    sendByte(8'hAA, a);
    sendByte(8'h72, a);
    sendByte(8'h11, a);
    sendByte(8'h22, a);
    sendBits(8'hC0, 3);
    scl = 1'b0; tick(2);
    busStop(); tick(10);
    chk("R9 mid-byte stop no busy", busyRises - rb, 0);
    chk("R9 mid-byte stop no write", wrCnt - wb, 0);
    cmpPage("R9 page untouched", 7);

    // R9: repeated start discards the staged bytes
    wb = wrCnt;
    busStart();
    sendByte(8'hAA, a);
    sendByte(8'h30, a);
    sendByte(8'h91, a);
    sendByte(8'h92, a);
    busStart();
    sendByte(8'hAA, a);  chk("R9 restart select ack", {31'h0, a}, 1);
    sendByte(8'h38, a);
    sendByte(8'h5A, a);
    expMem[8'h38] = 8'h5A;
    busStop();
    waitIdle();
    chk("R9 only restarted byte written", wrCnt - wb, 1);
    cmpPage("R9 page after restart", 3);

    // Sweep all start locations with several lengths (R3, R4, R5, R6)
    for (int t = 0; t < 64; t++) begin
      int cnt;
      case (t / 16)
        0: cnt = 1;
        1: cnt = 12;
        2: cnt = 13;
        default: cnt = 17;
      endcase
      pageWrite(t, (t * 5) % 16, t % 16, cnt);
    end

    // R7: a transaction sent during busy is ignored
    busStart();
    sendByte(8'hAA, a);
    sendByte(8'hE4, a);
    sendByte(8'h3C, a);
    expMem[8'hE4] = 8'h3C;
    busStop();
    wb = wrCnt;
    busStart();
    sendByte(8'hAA, a);  chk("R7 no ack while busy", {31'h0, a}, 0);
    sendByte(8'hE9, a);  chk("R7 no ack while busy", {31'h0, a}, 0);
    busStop();
    waitIdle();
    chk("R7 busy length unchanged", lastLen, BUSY);
    chk("R7 only first commit written", wrCnt - wb, 1);
    cmpPage("R7 page after lockout", 14);
    pageWrite(99, 14, 9, 2);

    for (int i = 0; i < 256; i++)
      chk("R6 full array", {24'h0, benchMem[i]}, {24'h0, expMem[i]});

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule